// File: doc/BRIEF.md
# Conditional Branch Resolver

This combinational unit sits beside the decode stage of a 32-bit integer pipeline and says, for the instruction word in flight, whether it is a conditional branch, whether that branch goes, whether the return address must be written, and whether the instruction after the branch must be squashed. It looks at the six-bit primary opcode, the five-bit fields in the rs and rt positions, the two source operand values read from the register file, and one condition flag from each of two coprocessors.

Three families are recognised. The first is the group of primary-opcode branches that compare two registers for equality or test one register against zero. The second is the register-immediate group, where the rt field acts as a sub-opcode and picks a sign test, with or without link. The third is the coprocessor group, which branches on a coprocessor flag being true or false. Each family has a "likely" flavour that squashes the delay slot when the branch falls through. Target arithmetic and fetch redirection are left to the neighbouring logic.

Top module: `branch_cond_unit`

## Requirements
- R1: Opcodes 0x04 (equal) and 0x05 (not equal), and their likely forms 0x14 and 0x15, are valid branches; they go when the rs value equals the rt value (0x04/0x14) or differs from it (0x05/0x15).
- R2: Opcodes 0x06 and 0x16 go when the rs value, read as signed 32-bit, is zero or negative; opcodes 0x07 and 0x17 go when it is above zero. The rt value plays no part.
- R3: With opcode 0x01, rt field codes 0x00 and 0x02 go when rs is negative, codes 0x01 and 0x03 go when rs is zero or positive; 0x02 and 0x03 are the likely forms.
- R4: With opcode 0x01, rt field codes 0x10 to 0x13 make the same four tests as codes 0x00 to 0x03 and assert link_req whether taken or not.
- R5: Opcode 0x11 uses flag bit 0 and opcode 0x12 uses flag bit 1, only when the rs field is 0x08; rt field bit 0 set means go when the flag is 1, clear means go when it is 0; rt field bit 1 set marks the likely form; rt field bits 4..2 are ignored.
- R6: squash_slot is 1 exactly when a valid likely-form branch is not taken; a non-likely branch never asserts it.
- R7: Every other opcode, every other opcode 0x01 sub-code, and opcodes 0x11/0x12 with another rs field, give is_branch=0, taken=0, link_req=0 and squash_slot=0.
- R8: link_req is never asserted outside the opcode 0x01 codes 0x10 to 0x13.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 6 | Primary opcode of the instruction |
| rs_field | input | 5 | rs field, selects the branch sub-group under coprocessor opcodes |
| rt_field | input | 5 | rt field, sub-opcode for register-immediate and coprocessor branches |
| rs_val | input | 32 | First source operand value |
| rt_val | input | 32 | Second source operand value |
| cop_flag | input | 2 | Condition flags: bit 0 first coprocessor, bit 1 second |
| is_branch | output | 1 | Instruction is a recognised conditional branch |
| taken | output | 1 | Branch condition holds |
| link_req | output | 1 | Return address must be written |
| squash_slot | output | 1 | Delay-slot instruction must be annulled |

## Verification
The two functions that coincide in one cycle are the link request and the squash of the delay slot: a likely-with-link sign test that falls through must raise both at once, while a taken one raises link alone. The sweep drives every opcode and every rt code against operands that are negative, zero, positive, equal and unequal, so codes 0x12 and 0x13 under opcode 0x01 reach both outcomes, and each output bit is compared with an arithmetic model of the requirements.

// File: rtl/bcu_pkg.sv
package bcu_pkg;

    localparam int OPC_W     = 6;
    localparam int FLD_W     = 5;
    localparam int NUM_COP   = 2;
    localparam int COP_IDX_W = (NUM_COP > 1) ? $clog2(NUM_COP) : 1;

    localparam logic [OPC_W-1:0] OPC_REGIMM   = 6'h01;
    localparam logic [OPC_W-1:0] OPC_COP_BASE = 6'h11;
    localparam logic [FLD_W-1:0] RS_COND_BR   = 5'h08;

    typedef enum logic [2:0] {
        CK_NONE,
        CK_EQ,
        CK_NE,
        CK_LEZ,
        CK_GTZ,
        CK_LTZ,
        CK_GEZ,
        CK_COP
    } cond_kind_e;

    typedef struct packed {
        logic                 valid;
        cond_kind_e           kind;
        logic                 link;
        logic                 likely;
        logic [COP_IDX_W-1:0] cop_idx;
        logic                 want_true;
    } br_dec_t;

    typedef struct packed {
        logic eq;
        logic neg;
        logic zero;
    } cmp_flags_t;

    function automatic logic eval_cond(cond_kind_e k, cmp_flags_t f,
                                       logic flag, logic want_true);
        logic r;
        case (k)
            CK_EQ:   r = f.eq;
            CK_NE:   r = !f.eq;
            CK_LEZ:  r = f.neg || f.zero;
            CK_GTZ:  r = !f.neg && !f.zero;
            CK_LTZ:  r = f.neg;
            CK_GEZ:  r = !f.neg;
            CK_COP:  r = (flag == want_true);
            default: r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bcu_decode.sv
module bcu_decode
    import bcu_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    input  logic [FLD_W-1:0] rs_field,
    input  logic [FLD_W-1:0] rt_field,
    output br_dec_t          dec
);

    logic [NUM_COP-1:0]   cop_hit;
    logic [COP_IDX_W-1:0] cop_sel;

    generate
        for (genvar gi = 0; gi < NUM_COP; gi++) begin : g_cop
            assign cop_hit[gi] = (opcode == OPC_COP_BASE + OPC_W'(gi)) &&
                                 (rs_field == RS_COND_BR);
        end
    endgenerate

    always_comb begin
        cop_sel = '0;
        for (int i = 0; i < NUM_COP; i++) begin
            if (cop_hit[i]) cop_sel = COP_IDX_W'(i);
        end
    end

    logic prim_br;
    logic imm_br;
    assign prim_br = !opcode[5] && !opcode[3] && opcode[2];
    assign imm_br  = (opcode == OPC_REGIMM) && (rt_field[3:2] == 2'b00);

    always_comb begin
        dec = '0;
        dec.kind = CK_NONE;
        if (prim_br) begin
            dec.valid  = 1'b1;
            dec.likely = opcode[4];
            case (opcode[1:0])
                2'd0:    dec.kind = CK_EQ;
                2'd1:    dec.kind = CK_NE;
                2'd2:    dec.kind = CK_LEZ;
                default: dec.kind = CK_GTZ;
            endcase
        end else if (imm_br) begin
            dec.valid  = 1'b1;
            dec.link   = rt_field[4];
            dec.likely = rt_field[1];
            dec.kind   = rt_field[0] ? CK_GEZ : CK_LTZ;
        end else if (|cop_hit) begin
            dec.valid     = 1'b1;
            dec.kind      = CK_COP;
            dec.cop_idx   = cop_sel;
            dec.likely    = rt_field[1];
            dec.want_true = rt_field[0];
        end
    end

endmodule

// File: rtl/bcu_compare.sv
module bcu_compare
    import bcu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output cmp_flags_t        flags
);

    always_comb begin
        flags.eq   = (a == b);
        flags.neg  = a[DATA_W-1];
        flags.zero = (a == '0);
    end

endmodule

// File: rtl/bcu_resolve.sv
module bcu_resolve
    import bcu_pkg::*;
(
    input  br_dec_t            dec,
    input  cmp_flags_t         flags,
    input  logic [NUM_COP-1:0] cop_flag,
    output logic               is_branch,
    output logic               taken,
    output logic               link_req,
    output logic               squash_slot
);

    logic cond;
    assign cond = eval_cond(dec.kind, flags, cop_flag[dec.cop_idx], dec.want_true);

    always_comb begin
        is_branch   = dec.valid;
        taken       = dec.valid && cond;
        link_req    = dec.valid && dec.link;
        squash_slot = dec.valid && dec.likely && !cond;
    end

endmodule

// File: rtl/branch_cond_unit.sv
module branch_cond_unit
    import bcu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [OPC_W-1:0]   opcode,
    input  logic [FLD_W-1:0]   rs_field,
    input  logic [FLD_W-1:0]   rt_field,
    input  logic [DATA_W-1:0]  rs_val,
    input  logic [DATA_W-1:0]  rt_val,
    input  logic [NUM_COP-1:0] cop_flag,
    output logic               is_branch,
    output logic               taken,
    output logic               link_req,
    output logic               squash_slot
);

    br_dec_t    dec;
    cmp_flags_t flags;

    bcu_decode u_decode (
        .opcode   (opcode),
        .rs_field (rs_field),
        .rt_field (rt_field),
        .dec      (dec)
    );

    bcu_compare #(.DATA_W(DATA_W)) u_compare (
        .a     (rs_val),
        .b     (rt_val),
        .flags (flags)
    );

    bcu_resolve u_resolve (
        .dec         (dec),
        .flags       (flags),
        .cop_flag    (cop_flag),
        .is_branch   (is_branch),
        .taken       (taken),
        .link_req    (link_req),
        .squash_slot (squash_slot)
    );

endmodule

// File: rtl/branch_cond_unit_chk.sv
module branch_cond_unit_chk
    import bcu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic [OPC_W-1:0]  opcode,
    input logic [FLD_W-1:0]  rt_field,
    input logic [DATA_W-1:0] rs_val,
    input logic [DATA_W-1:0] rt_val,
    input logic              is_branch,
    input logic              taken,
    input logic              link_req,
    input logic              squash_slot
);

    always_comb begin
        p_invalid_quiet_r7: assert (is_branch || (!taken && !link_req && !squash_slot))
            else $error("non-branch drove an output");
        p_squash_untaken_r6: assert (!squash_slot || (is_branch && !taken))
            else $error("squash on taken or invalid branch");
        p_link_source_r8: assert (!link_req || (opcode == OPC_REGIMM && rt_field[4]))
            else $error("link outside link forms");
        p_equal_r1: assert (opcode != 6'h04 || (taken == (rs_val == rt_val)))
            else $error("equal branch decision wrong");
        p_positive_r2: assert (opcode != 6'h07 ||
                               (taken == (!rs_val[DATA_W-1] && rs_val != '0)))
            else $error("greater-than-zero decision wrong");
    end

endmodule

bind branch_cond_unit branch_cond_unit_chk #(.DATA_W(DATA_W)) chk_i (
    .opcode      (opcode),
    .rt_field    (rt_field),
    .rs_val      (rs_val),
    .rt_val      (rt_val),
    .is_branch   (is_branch),
    .taken       (taken),
    .link_req    (link_req),
    .squash_slot (squash_slot)
);

// File: tb/branch_cond_unit_tb_top.sv
`timescale 1ns/1ps
module branch_cond_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  opcode = '0;
    logic [4:0]  rs_field = '0;
    logic [4:0]  rt_field = '0;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic [1:0]  cop_flag = '0;
    logic        is_branch, taken, link_req, squash_slot;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    branch_cond_unit #(.DATA_W(32)) dut_i (
        .opcode      (opcode),
        .rs_field    (rs_field),
        .rt_field    (rt_field),
        .rs_val      (rs_val),
        .rt_val      (rt_val),
        .cop_flag    (cop_flag),
        .is_branch   (is_branch),
        .taken       (taken),
        .link_req    (link_req),
        .squash_slot (squash_slot)
    );

    // expected {is_branch, taken, link_req, squash_slot}
    function automatic logic [3:0] model(input int op, input int rsf, input int rtf,
                                         input logic [31:0] a, input logic [31:0] b,
                                         input logic [1:0] cf, output string req);
        bit v = 0, t = 0, l = 0, lk = 0;
        longint sa = longint'($signed(a));
        req = "R7";
        if (op == 4 || op == 5 || op == 20 || op == 21) begin
            // R1: equal / not equal, 0x14/0x15 likely
            v = 1; lk = (op >= 20);
            t = ((op % 16) == 4) ? (a == b) : (a != b);
            req = "R1";
        end else if (op == 6 || op == 7 || op == 22 || op == 23) begin
            // R2: signed test against zero
            v = 1; lk = (op >= 20);
            t = ((op % 16) == 6) ? (sa <= 0) : (sa > 0);
            req = "R2";
        end else if (op == 1 && ((rtf >= 0 && rtf <= 3) || (rtf >= 16 && rtf <= 19))) begin
            // R3 plain sign tests, R4 with link
            v = 1; l = (rtf >= 16); lk = ((rtf % 16) >= 2);
            t = ((rtf % 2) == 1) ? (sa >= 0) : (sa < 0);
            req = l ? "R4" : "R3";
        end else if ((op == 17 || op == 18) && rsf == 8) begin
            // R5: coprocessor flag branch
            v = 1; lk = ((rtf / 2) % 2) == 1;
            t = (cf[op - 17] == logic'(rtf % 2));
            req = "R5";
        end
        if (v && lk && !t && req == "R1") req = "R6";
        return {v, t, v && l, v && lk && !t};
    endfunction

    task automatic apply(input int op, input int rsf, input int rtf,
                         input logic [31:0] a, input logic [31:0] b, input logic [1:0] cf);
        logic [3:0] exp;
        string req;
        @(negedge clk);
        opcode = 6'(op); rs_field = 5'(rsf); rt_field = 5'(rtf);
        rs_val = a; rt_val = b; cop_flag = cf;
        #1;
        exp = model(op, rsf, rtf, a, b, cf, req);
        n_vec++;
        if ({is_branch, taken, link_req, squash_slot} !== exp) begin
            n_bad++;
            $display("FAIL %s op=%0h rs=%0h rt=%0h a=%0h b=%0h cf=%0b actual=%b expected=%b",
                     req, op, rsf, rtf, a, b, cf,
                     {is_branch, taken, link_req, squash_slot}, exp);
        end
    endtask

    logic [31:0] va [6] = '{32'h0, 32'h5, 32'h5, 32'h8000_0000, 32'hFFFF_FFFF, 32'h1};
    logic [31:0] vb [6] = '{32'h0, 32'h5, 32'h6, 32'h0, 32'h1, 32'h8000_0000};
    int          rsv [3] = '{8, 0, 9};

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // reset state: all-zero inputs, opcode 0 is no branch (R7)
        apply(0, 0, 0, 32'h0, 32'h0, 2'b00);
        // R6 and R4 together: likely-with-link not taken, then taken
        apply(1, 0, 19, 32'hFFFF_FFFF, 32'h0, 2'b00);
        apply(1, 0, 18, 32'hFFFF_FFFF, 32'h0, 2'b00);
        // R8: link never outside REGIMM link codes; covered by the sweep below
        for (int op = 0; op < 64; op++)
            for (int rt = 0; rt < 32; rt++)
                for (int r = 0; r < 3; r++)
                    for (int p = 0; p < 6; p++)
                        for (int c = 0; c < 4; c++) begin
                            if (r != 0 && !(op == 17 || op == 18)) continue;
                            if (c != 0 && !(op == 17 || op == 18)) continue;
                            apply(op, rsv[r], rt, va[p], vb[p], 2'(c));
                        end
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (190000) @(posedge clk);
                n_bad++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule